// File: doc/BRIEF.md
# Dual-Channel Parallel Converter Register Interface

This block is the digital front end of a two-channel converter that shares one parallel data bus. A host drives an active-low chip select, a read/write strobe and a channel-select line. A write puts a word into the latch of the addressed channel, and that latch drives the channel's output code. A read places the addressed channel's stored code on the same bus, which is bidirectional. When no read is in progress the block leaves the bus at high impedance.

All bus pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer before the block decodes it. As long as chip select and read/write both stay low, the addressed latch follows the bus on every clock. The latch keeps whatever value it last took when the access ends. If the strobe or the channel select changes while chip select is low, the block ends the current access and starts a new one. The data width can be set to 8, 10 or 12 bits. Bit 0 is the least significant bit.

Top module: `dual_dac_bus_if`

## Requirements
- R1: A low level on `chan_sel_i` addresses channel A (`code_a_o`). A high level addresses channel B (`code_b_o`).
- R2: While `cs_n_i` is high, neither code changes, whatever happens on the data bus, the strobe or the channel select, and the block does not drive the bus.
- R3: With `cs_n_i` low and `rw_i` low, a word presented on `data_io` appears, bit for bit with bit 0 as the LSB, on the addressed channel's code output on the third rising clock edge after it was applied.
- R4: With `cs_n_i` low and `rw_i` high, the block drives the addressed channel's stored code onto `data_io` starting from the second rising clock edge after the access began.
- R5: While a write access is held, every change on the data bus is passed to the addressed code output with the same three-edge latency.
- R6: After a synchronous reset (`rst_n` low), both code outputs are zero and the bus is released.
- R7: The block releases `data_io` to high impedance no later than the second rising edge after a read ends, whether `cs_n_i` rises or `rw_i` falls.
- R8: When `cs_n_i` rises at the end of a write, the latch keeps the last bus value it took, even if the bus then changes or floats.
- R9: A write to one channel never changes the other channel's code.
- R10: Changing `chan_sel_i` or `rw_i` while `cs_n_i` stays low ends the current access and starts a new one. The previously addressed latch holds its value, and the new access acts on its own target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_sel_i | input | 1 | Channel select: 0 addresses A, 1 addresses B |
| cs_n_i | input | 1 | Chip select, active low |
| rw_i | input | 1 | Strobe: 1 selects read, 0 selects write |
| data_io | inout | DATA_W | Shared parallel data bus |
| code_a_o | output | DATA_W | Channel A output code |
| code_b_o | output | DATA_W | Channel B output code |

## Verification
The hardest case to reach is a change of access while chip select stays low. A write that turns into a read, or a write whose channel select flips, must retarget cleanly. The bus must not be driven by both sides, and the old latch must not pick up a floating bus value. The stimulus gets there with directed sequences. These flip `chan_sel_i` at the same moment the bus word changes, or release the bench driver on the same clock that `rw_i` rises. Because the bus pins are synchronized at equal depth, that is the only ordering that is safe. Randomized writes, reads and idle bus noise around these sequences are compared against a two-entry model.

// File: rtl/dac_bus_pkg.sv
// Shared definitions for the dual-channel converter bus interface.
package dac_bus_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;
endpackage

// File: rtl/dac_bus_sync.sv
// Two-flop synchronizer for a bundle of asynchronous bus pins.
// Assumes each bit is sampled independently. All bits share one depth,
// so pins that change together arrive together.
module dac_bus_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [63:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two-stage capture with synchronous reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL[WIDTH-1:0];
            stage2_q <= RST_VAL[WIDTH-1:0];
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/dac_bus_decode.sv
// Decodes the synchronized control pins into one access type,
// per-channel write enables and a bus output enable.
// Assumes the inputs are already synchronized to clk.
module dac_bus_decode
    import dac_bus_pkg::*;
(
    input  logic              cs_n_s,
    input  logic              rw_s,
    input  logic              sel_s,
    output acc_e              acc_o,
    output logic [NUM_CH-1:0] wr_en_o,
    output logic              oe_o
);
    // Classify the present access from the control levels.
    always_comb begin
        if (cs_n_s)     acc_o = ACC_IDLE;
        else if (rw_s)  acc_o = ACC_READ;
        else            acc_o = ACC_WRITE;
    end

    // Steer the write to one channel and enable the bus on reads.
    always_comb begin
        wr_en_o = '0;
        if (acc_o == ACC_WRITE) wr_en_o[sel_s] = 1'b1;
        oe_o = (acc_o == ACC_READ);
    end
endmodule

// File: rtl/dac_chan_reg.sv
// One channel latch. It loads din on every clock while wr_en is high,
// which gives the transparent behaviour, and otherwise holds.
// Assumes din and wr_en come from the synchronized domain.
module dac_chan_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code_q
);
    // Latch storage with synchronous clear to zero scale.
    always_ff @(posedge clk) begin
        if (!rst_n)     code_q <= '0;
        else if (wr_en) code_q <= din;
    end

    // R6: the first edge after reset is released still shows zero.
    assert_reset_zero_R6: assert property (@(posedge clk)
        $rose(rst_n) |-> code_q == '0);

    // R2 / R9 / R8: the latch does not move without its own enable.
    assert_hold_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_q));

    // R5: while enabled, the latch takes the bus word one edge later.
    assert_follow_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> code_q == $past(din));
endmodule

// File: rtl/dual_dac_bus_if.sv
// Bus-side register interface for a two-channel converter.
// The shared bidirectional bus, chip select, strobe and channel select are
// synchronized, decoded and applied to two channel latches. Reads drive the
// bus only while a read is decoded. Assumes the host does not drive the
// bus during reads.
module dual_dac_bus_if
    import dac_bus_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_sel_i,
    input  logic              cs_n_i,
    input  logic              rw_i,
    inout  wire  [DATA_W-1:0] data_io,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o
);
    localparam int CTRL_W = 3;

    logic [CTRL_W-1:0] ctrl_s;
    logic [DATA_W-1:0] data_s;
    logic              cs_n_s;
    logic              rw_s;
    logic              sel_s;
    acc_e              acc;
    logic [NUM_CH-1:0] wr_en;
    logic              bus_oe;
    logic [DATA_W-1:0] codes [NUM_CH];
    logic [DATA_W-1:0] rd_word;

    // Control pins: idle level is chip select high and strobe high.
    dac_bus_sync #(.WIDTH(CTRL_W), .RST_VAL(64'd6)) u_ctrl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, rw_i, chan_sel_i}),
        .sync_o  (ctrl_s)
    );

    // Data pins use the same depth as the control pins, so they stay aligned.
    dac_bus_sync #(.WIDTH(DATA_W), .RST_VAL(64'd0)) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (data_io),
        .sync_o  (data_s)
    );

    assign cs_n_s = ctrl_s[2];
    assign rw_s   = ctrl_s[1];
    assign sel_s  = ctrl_s[0];

    dac_bus_decode u_decode (
        .cs_n_s  (cs_n_s),
        .rw_s    (rw_s),
        .sel_s   (sel_s),
        .acc_o   (acc),
        .wr_en_o (wr_en),
        .oe_o    (bus_oe)
    );

    // One latch per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dac_chan_reg #(.DATA_W(DATA_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en[ch]),
            .din    (data_s),
            .code_q (codes[ch])
        );
    end

    assign code_a_o = codes[0];
    assign code_b_o = codes[1];

    // Readback mux and tri-state bus driver.
    assign rd_word = codes[sel_s];
    assign data_io = bus_oe ? rd_word : {DATA_W{1'bz}};

    // R9: at most one channel is written in any cycle.
    assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R7 / R2: chip select high on two straight edges leaves the bus released.
    assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i)) |=> !bus_oe);

    // R4: a read never coincides with a write enable.
    assert_read_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (wr_en == '0));

    // R1: channel B is written only while it is addressed.
    assert_chan_b_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[1] |-> (acc == ACC_WRITE) && sel_s);
endmodule

// File: tb/dual_dac_bus_if_bench.sv
`timescale 1ns/1ps
module dual_dac_bus_if_bench;
    localparam int W = 12;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_sel = 1'b0;
    logic cs_n = 1'b1;
    logic rw = 1'b1;
    logic tb_oe = 1'b0;
    logic [W-1:0] tb_dat = '0;
    wire  [W-1:0] bus;
    logic [W-1:0] code_a, code_b;

    logic [W-1:0] mdl [2];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign bus = tb_oe ? tb_dat : {W{1'bz}};
    pullup pu_bus[W-1:0] (bus);

    dual_dac_bus_if #(.DATA_W(W)) u_dual_dac_bus_if (
        .clk(clk), .rst_n(rst_n), .chan_sel_i(chan_sel), .cs_n_i(cs_n),
        .rw_i(rw), .data_io(bus), .code_a_o(code_a), .code_b_o(code_b)
    );

    function automatic logic [W-1:0] exp_code(input int ch);
        return mdl[ch];
    endfunction

    function automatic logic [W-1:0] act_code(input int ch);
        return (ch == 0) ? code_a : code_b;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_both(input string req);
        chk(req, code_a, exp_code(0));
        chk(req, code_b, exp_code(1));
    endtask

    // Write one word, check R3 latency, the other channel (R9) and hold (R8).
    task automatic do_write(input int ch, input logic [W-1:0] val);
        chan_sel = ch[0]; rw = 1'b0; cs_n = 1'b0; tb_oe = 1'b1; tb_dat = val;
        mdl[ch] = val;
        cyc(3);
        chk(ch == 0 ? "R3 R1 write A" : "R3 R1 write B", act_code(ch), exp_code(ch));
        chk("R9 other channel", act_code(1 - ch), exp_code(1 - ch));
        cs_n = 1'b1; tb_oe = 1'b0;
        cyc(4);
        chk("R8 hold after end", act_code(ch), exp_code(ch));
    endtask

    // Read one channel, check R4 data and R7 release.
    task automatic do_read(input int ch);
        tb_oe = 1'b0; chan_sel = ch[0]; rw = 1'b1; cs_n = 1'b0;
        cyc(2);
        chk("R4 readback", bus, exp_code(ch));
        cs_n = 1'b1;
        cyc(2);
        if (exp_code(ch) != ONES) chk("R7 release", bus, ONES);
    endtask

    initial begin
        void'($urandom(32'd4242));
        mdl[0] = '0; mdl[1] = '0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        check_both("R6 reset zero");
        chk("R6 bus released", bus, ONES);

        do_write(0, 12'h5A3);
        do_write(1, 12'h0C7);
        do_read(0);
        do_read(1);
        do_write(0, ONES);
        do_write(1, 12'h000);
        do_read(0);
        do_write(1, 12'h001);
        do_read(1);

        // R5: transparent follow while the write is held.
        chan_sel = 1'b1; rw = 1'b0; cs_n = 1'b0; tb_oe = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tb_dat = W'($urandom);
            mdl[1] = tb_dat;
            cyc(3);
            chk("R5 follow", code_b, exp_code(1));
            chk("R9 A untouched", code_a, exp_code(0));
        end

        // R10: retarget to A mid-access with a new word; B keeps the old one.
        chan_sel = 1'b0; tb_dat = 12'h3E9; mdl[0] = 12'h3E9;
        cyc(3);
        chk("R10 new target", code_a, exp_code(0));
        chk("R10 old target holds", code_b, exp_code(1));

        // R10: write turns into read without raising chip select.
        tb_oe = 1'b0; rw = 1'b1;
        cyc(2);
        chk("R10 write to read", bus, exp_code(0));
        check_both("R10 no float captured");

        // R7: read ends by the strobe falling; bench drives only after release.
        rw = 1'b0;
        cyc(2);
        chk("R7 release on strobe", bus, ONES);
        tb_oe = 1'b1; tb_dat = exp_code(0);
        cyc(3);
        cs_n = 1'b1; tb_oe = 1'b0;
        cyc(3);

        // R2: activity with chip select high is ignored.
        for (int i = 0; i < 6; i++) begin
            rw = 1'(i); chan_sel = 1'(i >> 1); tb_oe = ~rw; tb_dat = W'($urandom);
            cyc(3);
            check_both("R2 codes unchanged");
            if (!tb_oe) chk("R2 bus undriven", bus, ONES);
        end
        tb_oe = 1'b0; rw = 1'b1;
        cyc(2);

        // Randomized mix.
        for (int i = 0; i < 40; i++) begin
            int ch;
            ch = int'($urandom_range(1, 0));
            if ($urandom_range(1, 0) == 1) do_write(ch, W'($urandom));
            else do_read(ch);
        end

        // R6: reset in the middle of traffic clears both channels.
        rst_n = 1'b0; mdl[0] = '0; mdl[1] = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check_both("R6 re-reset");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule